// File: doc/BRIEF.md
# Line-Pair Summation Field Generator

This block converts a stream of full-frame sensor rows into interlaced fields. Every row of the frame arrives during each field time, and the block builds one field from each frame. In the summing mode it adds two vertically adjacent rows pixel by pixel into one output line, which doubles the signal level. The two-row window steps down by two rows per output line. On an odd field the window begins at row 0 (rows 0+1, 2+3, ...). On an even field it begins at row 1 (rows 1+2, 3+4, ...). The two fields therefore carry different row pairs, and no field is just a subset of the rows.

One input row is held in a line buffer. The first row of each pair is written to the buffer. When the second row arrives, each of its pixels is added to the stored pixel in the same column, and the sum is emitted with a valid strobe. Two other modes exist. The progressive mode passes every row through unchanged. The field-pick mode discards even-parity frames and passes odd-parity frames through unchanged. The output carries its own start-of-field and end-of-line markers and a parity tag.

Top module: `line_pair_field`

## Requirements
- R1: Each output pixel appears one clock after the input pixel that completes it (`out_valid` high). `out_sof` marks the first output pixel of a field. `out_eol` marks the last pixel of each output line. Both markers appear only with `out_valid`.
- R2: In summing mode (`in_mode` = 2'b00, or 2'b11, which behaves the same) with `in_field_odd` = 1, output line k is the pixelwise sum of rows 2k and 2k+1. No output is produced while row 2k is received.
- R3: In summing mode with `in_field_odd` = 0, row 0 produces no output, and output line k is the pixelwise sum of rows 2k+1 and 2k+2.
- R4: In summing mode, a final row that has no partner below it produces no output line. The line count per field is floor(rows/2) on an odd field and floor((rows-1)/2) on an even field.
- R5: In progressive mode (`in_mode` = 2'b01), every row is output unchanged, zero-extended by one bit, one line per input row.
- R6: In field-pick mode (`in_mode` = 2'b10), a frame with `in_field_odd` = 0 produces no output. A frame with `in_field_odd` = 1 is passed through unchanged, as in R5.
- R7: `in_mode` and `in_field_odd` are sampled only on the pixel that carries `in_sof`. Changing them later in the frame has no effect on that frame's output.
- R8: `out_field_odd` on every output pixel equals the parity that was sampled at the start of its frame.
- R9: While reset is asserted, and after it is released, `out_valid`, `out_sof` and `out_eol` stay low until an input pixel produces output.
- R10: The sum output is PIX_W+1 bits wide. Two full-scale pixels produce exactly 2*(2^PIX_W-1), with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_data | input | PIX_W | Input pixel value |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a row |
| in_field_odd | input | 1 | Field parity, 1 = odd (sampled with in_sof) |
| in_mode | input | 2 | 00/11 sum, 01 progressive, 10 field-pick (sampled with in_sof) |
| out_valid | output | 1 | Output pixel strobe |
| out_data | output | PIX_W+1 | Output pixel (sum or zero-extended pass) |
| out_sof | output | 1 | First output pixel of a field |
| out_eol | output | 1 | Last pixel of an output line |
| out_field_odd | output | 1 | Parity tag of the frame being output |

## Verification
The hardest situation to reach from the ports is the bottom of an even field. There, the last row must be stored but never emitted, and the next frame's first row must not be summed with that stale buffer content. The bench reaches it by sending an even-parity frame with an even row count directly before an odd-parity frame. The pixel values differ between frames, so a wrong pairing shows up as a wrong sum. Idle gaps placed inside rows, and mode and parity inputs toggled after the start-of-frame pixel, show that pairing depends only on the row and column counts and on the values sampled at the start of the frame.

// File: rtl/line_pair_field.sv
module line_pair_field #(
  parameter int PIX_W    = 8,
  parameter int MAX_COLS = 64,
  parameter int MAX_ROWS = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic             in_field_odd,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  output logic [PIX_W:0]   out_data,
  output logic             out_sof,
  output logic             out_eol,
  output logic             out_field_odd
);
  localparam int COL_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;
  localparam int ROW_W = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1;
  localparam int BUF_D = 1 << COL_W;
  localparam logic [1:0] MODE_PROG = 2'b01;
  localparam logic [1:0] MODE_PICK = 2'b10;

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             par_q, first_q;
  logic [1:0]       mode_q;
  logic [PIX_W-1:0] line_buf [BUF_D];

  wire [ROW_W-1:0] cur_row   = in_sof ? '0 : row_q;
  wire [COL_W-1:0] cur_col   = in_sof ? '0 : col_q;
  wire             cur_par   = in_sof ? in_field_odd : par_q;
  wire [1:0]       cur_mode  = in_sof ? in_mode : mode_q;
  wire             first_nxt = in_sof | first_q;

  wire [ROW_W-1:0] rel      = cur_row - {{(ROW_W-1){1'b0}}, ~cur_par};
  wire             skip_top = ~cur_par & (cur_row == '0);
  wire             summing  = (cur_mode != MODE_PROG) & (cur_mode != MODE_PICK);
  wire             passing  = (cur_mode == MODE_PROG) | ((cur_mode == MODE_PICK) & cur_par);
  wire             pair_ok  = in_valid & summing & ~skip_top;
  wire             store    = pair_ok & ~rel[0];
  wire             emit_sum = pair_ok & rel[0];
  wire             emit     = emit_sum | (in_valid & passing);

  always_ff @(posedge clk) begin
    if (store) line_buf[cur_col] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      par_q   <= 1'b0;
      mode_q  <= 2'b00;
      first_q <= 1'b0;
    end else if (in_valid) begin
      col_q   <= in_eol ? '0 : cur_col + 1'b1;
      if (in_eol) row_q <= cur_row + 1'b1;
      else        row_q <= cur_row;
      par_q   <= cur_par;
      mode_q  <= cur_mode;
      first_q <= emit ? 1'b0 : first_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_sof       <= 1'b0;
      out_eol       <= 1'b0;
      out_field_odd <= 1'b0;
    end else begin
      out_valid <= emit;
      out_sof   <= emit & first_nxt;
      out_eol   <= emit & in_eol;
      if (emit) begin
        out_data      <= emit_sum ? ({1'b0, line_buf[cur_col]} + {1'b0, in_data})
                                  : {1'b0, in_data};
        out_field_odd <= cur_par;
      end
    end
  end
endmodule

// File: rtl/line_pair_field_checks.sv
module line_pair_field_checks #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_data,
  input logic             in_sof,
  input logic             in_field_odd,
  input logic [1:0]       in_mode,
  input logic             out_valid,
  input logic [PIX_W:0]   out_data,
  input logic             out_sof,
  input logic             out_eol,
  input logic             out_field_odd
);
  assert_out_follows_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_marks_with_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof | out_eol) |-> out_valid);

  assert_first_row_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && in_sof && (in_mode == 2'b00 || in_mode == 2'b11)) |-> !out_valid);

  assert_prog_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && in_sof && in_mode == 2'b01)
      |-> (out_valid && out_sof && out_data == {1'b0, $past(in_data)}));

  assert_pick_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && in_sof && in_mode == 2'b10 && !in_field_odd) |-> !out_valid);

  assert_parity_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && in_valid && in_sof) && out_valid) |-> out_field_odd == $past(in_field_odd));
endmodule

bind line_pair_field line_pair_field_checks #(.PIX_W(PIX_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
  .in_field_odd(in_field_odd), .in_mode(in_mode), .out_valid(out_valid),
  .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol), .out_field_odd(out_field_odd)
);

// File: tb/tb_line_pair_field.sv
module tb_line_pair_field;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_field_odd = 1'b0;
  logic [PIX_W-1:0] in_data = '0;
  logic [1:0] in_mode = 2'b00;
  logic out_valid, out_sof, out_eol, out_field_odd;
  logic [PIX_W:0] out_data;

  line_pair_field #(.PIX_W(PIX_W), .MAX_COLS(64), .MAX_ROWS(2048)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eol(in_eol), .in_field_odd(in_field_odd), .in_mode(in_mode),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol), .out_field_odd(out_field_odd));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, lines_seen = 0;
  logic [PIX_W+3:0] q_item [$];
  string q_tag [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pix(int r, int c, int base, bit full);
    return full ? (1 << PIX_W) - 1 : (base + r * 16 + c * 3) & ((1 << PIX_W) - 1);
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_eol) lines_seen++;
      if (q_item.size() == 0) begin
        check(1'b0, "R1", "unexpected output pixel", int'(out_data), -1);
      end else begin
        logic [PIX_W+3:0] e;
        string t;
        e = q_item.pop_front();
        t = q_tag.pop_front();
        check(out_data == e[PIX_W+3:3], t, "pixel value", int'(out_data), int'(e[PIX_W+3:3]));
        check({out_sof, out_eol} == e[2:1], "R1", "sof/eol markers", int'({out_sof, out_eol}), int'(e[2:1]));
        check(out_field_odd == e[0], "R8", "parity tag", int'(out_field_odd), int'(e[0]));
      end
    end
  end

  task automatic drive_frame(input int nr, input int nc, input bit par, input logic [1:0] md,
                             input bit scr, input bit full, input int base, input string tag);
    int exp_lines = 0;
    bit first = 1'b1;
    for (int r = 0; r < nr; r++) begin
      for (int c = 0; c < nc; c++) begin
        bit em = 1'b0;
        int v = 0;
        if (md == 2'b01 || (md == 2'b10 && par)) begin
          em = 1'b1;
          v = pix(r, c, base, full);
        end else if (md == 2'b00 || md == 2'b11) begin
          int s = par ? 0 : 1;
          if (r > s - 1 + 1 - 1 && r >= s && ((r - s) % 2) == 1) begin
            em = 1'b1;
            v = pix(r - 1, c, base, full) + pix(r, c, base, full);
          end
        end
        if (em) begin
          q_item.push_back({v[PIX_W:0], first, (c == nc - 1), par});
          q_tag.push_back(tag);
          first = 1'b0;
          if (c == nc - 1) exp_lines++;
        end
      end
    end
    lines_seen = 0;
    for (int r = 0; r < nr; r++) begin
      for (int c = 0; c < nc; c++) begin
        if (((r + c + base) % 4) == 3) begin
          in_valid = 1'b0;
          in_data = 8'hA5;
          in_sof = 1'b1;
          in_eol = 1'b1;
          @(posedge clk); #1;
        end
        in_valid = 1'b1;
        in_data = pix(r, c, base, full);
        in_sof = (r == 0 && c == 0);
        in_eol = (c == nc - 1);
        in_field_odd = (scr && !in_sof) ? ~par : par;
        in_mode = (scr && !in_sof) ? ~md : md;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_eol = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(lines_seen == exp_lines, "R4", {tag, " field line count"}, lines_seen, exp_lines);
    check(q_item.size() == 0, tag, "outputs still pending", q_item.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_sof == 1'b0 && out_eol == 1'b0, "R9", "outputs in reset",
          int'({out_valid, out_sof, out_eol}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R9", "idle after reset", int'(out_valid), 0);
    @(posedge clk); #1;

    drive_frame(5, 6, 1'b1, 2'b00, 1'b0, 1'b0, 1,  "R2");
    drive_frame(5, 6, 1'b0, 2'b00, 1'b0, 1'b0, 7,  "R3");
    drive_frame(6, 6, 1'b0, 2'b00, 1'b1, 1'b0, 20, "R7");
    drive_frame(4, 5, 1'b1, 2'b11, 1'b0, 1'b0, 33, "R2");
    drive_frame(3, 4, 1'b1, 2'b01, 1'b1, 1'b0, 50, "R5");
    drive_frame(3, 4, 1'b0, 2'b10, 1'b0, 1'b0, 61, "R6");
    drive_frame(3, 4, 1'b1, 2'b10, 1'b1, 1'b0, 70, "R6");
    drive_frame(2, 6, 1'b1, 2'b00, 1'b0, 1'b1, 0,  "R10");
    drive_frame(7, 3, 1'b0, 2'b00, 1'b0, 1'b0, 90, "R3");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule